// File: doc/BRIEF.md
# I2C Bus Recovery Controller

This block sits next to an I2C master and owns a pair of open-drain hooks onto the SCL and SDA wires. When it receives a kick, it first checks whether the clock wire can rise at all. If SCL stays low for longer than a programmable number of system clocks, it reports a clock-stuck error and leaves both wires alone.

If SCL is free but a device is holding SDA low, the block clocks SCL one pulse at a time, up to nine pulses. It samples SDA at the end of each high half-period and stops clocking as soon as SDA reads high. It then builds a STOP condition, so that a device left in the middle of a write sees the transfer end and cannot latch stray data. If SDA is still low after the last permitted pulse, the block gives up with a data-stuck error and does not retry.

Both wires are only ever pulled low or released. The sampled wire levels pass through a synchronizer before any decision uses them. The length of each SCL half-period is a parameter. The default is 500 system clocks, which gives 100 kHz at 100 MHz.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset both drive-low outputs are 0 and busy, done, ok, scl_err and sda_err are all 0.
- R2: A kick on an idle bus where both wires read high ends with ok=1 and no SCL pulse. No wire is driven during that run.
- R3: If SCL reads low for a number of consecutive cycles equal to timeout_i after a kick, the run ends with scl_err=1. SCL is never driven low during that run. timeout_i must be at least 4.
- R4: When SDA is held low, the block pulses SCL and stops pulsing at the first pulse whose high half shows SDA high. A device that frees SDA on its k-th SCL falling edge (k ≤ 9) therefore receives exactly k recovery pulses.
- R5: At most 9 recovery pulses are issued. If SDA is still low at the end of the ninth pulse, the run ends with sda_err=1, no STOP, and no further SCL activity.
- R6: After SDA is seen free, the block pulls SCL low, pulls SDA low, releases SCL, and then releases SDA while SCL is high (a STOP). That SCL low period lasts two half-periods. The run then ends with ok=1 and both wires released.
- R7: The block never pulls SDA low while SCL is released, so it can never create a START condition.
- R8: Every recovery pulse holds SCL low for exactly HALF_CYCLES system clocks.
- R9: done is high for exactly one cycle per run. While done is high, exactly one of ok, scl_err and sda_err is 1, and that flag holds until the next accepted kick.
- R10: A kick that arrives while busy=1 is ignored. The run in progress completes with its own pulse count and a single done.
- R11: busy is high from the cycle after an accepted kick until the cycle in which done rises, and busy is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Kick: begins a recovery attempt when idle |
| timeout_i | input | CNT_W | Cycles SCL may read low before it is declared stuck |
| scl_i | input | 1 | Sampled SCL wire level |
| sda_i | input | 1 | Sampled SDA wire level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Recovery attempt in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| ok_o | output | 1 | Last run freed the bus |
| scl_err_o | output | 1 | Last run found SCL stuck low |
| sda_err_o | output | 1 | Last run could not free SDA |

## Verification
The embedded properties check the following on every cycle:
- SDA is never pulled low while SCL is released, and it is let go only while SCL is released.
- done is a single-cycle strobe that carries exactly one result flag and coincides with busy falling.
- The number of SCL pulls in a run never exceeds the pulse limit plus the STOP.

Only the directed scenarios can show the outcomes that depend on how the bus behaves:
- the exact pulse count for a device that frees SDA after a given number of clock edges, including the ninth-pulse boundary;
- the STOP appearing on the wires;
- the stuck-clock timing and the absence of clocking during it;
- the low width of each pulse;
- a kick during a run being ignored.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHK_SCL,
    ST_CHK_SDA,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_STOP_LO,
    ST_STOP_SDA,
    ST_STOP_RISE,
    ST_STOP_END
  } rec_state_t;

  typedef enum logic [1:0] {
    RES_OK,
    RES_SCL,
    RES_SDA
  } rec_result_t;

endpackage

// File: rtl/i2crec_sync.sv
module i2crec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '1;
          else     stage[g] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '1;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/i2crec_count.sv
module i2crec_count #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt;

  assign hit = en && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int CNT_W       = 20,
  parameter int HALF_CYCLES = 500,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_drive_low_o,
  output logic             sda_drive_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o,
  output logic             scl_err_o,
  output logic             sda_err_o
);
  import i2crec_pkg::*;

  localparam int PC_W = $clog2(MAX_PULSES + 1);
  localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(HALF_CYCLES - 1);
  localparam logic [PC_W-1:0]  LAST_PC  = PC_W'(MAX_PULSES - 1);

  rec_state_t  state, state_nxt;
  rec_result_t fin_res;
  logic        fin;
  logic [PC_W-1:0] pulse_cnt;
  logic        pc_inc, pc_clr;
  logic        scl_s, sda_s;
  logic        timed_lo, watch_hi;
  logic        half_en, half_hit, stuck_en, stuck_hit, phase_clr;
  logic        accept;

  i2crec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   ({scl_s, sda_s})
  );

  assign timed_lo  = (state == ST_PULSE_LO) || (state == ST_STOP_LO) ||
                     (state == ST_STOP_SDA);
  assign watch_hi  = (state == ST_PULSE_HI) || (state == ST_STOP_RISE) ||
                     (state == ST_STOP_END);
  assign half_en   = timed_lo || (watch_hi && scl_s);
  assign stuck_en  = ((state == ST_CHK_SCL) || watch_hi) && !scl_s;
  assign phase_clr = (state_nxt != state);
  assign accept    = (state == ST_IDLE) && start_i;

  i2crec_count #(.W(CNT_W)) u_half (
    .clk   (clk),
    .rst   (rst),
    .clr   (phase_clr),
    .en    (half_en),
    .limit (HALF_LIM),
    .hit   (half_hit)
  );

  i2crec_count #(.W(CNT_W)) u_stuck (
    .clk   (clk),
    .rst   (rst),
    .clr   (phase_clr),
    .en    (stuck_en),
    .limit (timeout_i),
    .hit   (stuck_hit)
  );

  always_comb begin
    state_nxt = state;
    fin       = 1'b0;
    fin_res   = RES_OK;
    pc_inc    = 1'b0;
    pc_clr    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_i) state_nxt = ST_CHK_SCL;
      end
      ST_CHK_SCL: begin
        if (scl_s) begin
          state_nxt = ST_CHK_SDA;
        end else if (stuck_hit) begin
          fin = 1'b1; fin_res = RES_SCL; state_nxt = ST_IDLE;
        end
      end
      ST_CHK_SDA: begin
        if (sda_s) begin
          fin = 1'b1; fin_res = RES_OK; state_nxt = ST_IDLE;
        end else begin
          pc_clr = 1'b1; state_nxt = ST_PULSE_LO;
        end
      end
      ST_PULSE_LO: begin
        if (half_hit) state_nxt = ST_PULSE_HI;
      end
      ST_PULSE_HI: begin
        if (stuck_hit) begin
          fin = 1'b1; fin_res = RES_SCL; state_nxt = ST_IDLE;
        end else if (half_hit) begin
          if (sda_s) begin
            state_nxt = ST_STOP_LO;
          end else if (pulse_cnt == LAST_PC) begin
            fin = 1'b1; fin_res = RES_SDA; state_nxt = ST_IDLE;
          end else begin
            pc_inc = 1'b1; state_nxt = ST_PULSE_LO;
          end
        end
      end
      ST_STOP_LO: begin
        if (half_hit) state_nxt = ST_STOP_SDA;
      end
      ST_STOP_SDA: begin
        if (half_hit) state_nxt = ST_STOP_RISE;
      end
      ST_STOP_RISE: begin
        if (stuck_hit) begin
          fin = 1'b1; fin_res = RES_SCL; state_nxt = ST_IDLE;
        end else if (half_hit) begin
          state_nxt = ST_STOP_END;
        end
      end
      ST_STOP_END: begin
        if (stuck_hit) begin
          fin = 1'b1; fin_res = RES_SCL; state_nxt = ST_IDLE;
        end else if (half_hit) begin
          fin = 1'b1; fin_res = sda_s ? RES_OK : RES_SDA; state_nxt = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      pulse_cnt       <= '0;
      scl_drive_low_o <= 1'b0;
      sda_drive_low_o <= 1'b0;
      busy_o          <= 1'b0;
      done_o          <= 1'b0;
      ok_o            <= 1'b0;
      scl_err_o       <= 1'b0;
      sda_err_o       <= 1'b0;
    end else begin
      state           <= state_nxt;
      if (pc_clr)      pulse_cnt <= '0;
      else if (pc_inc) pulse_cnt <= pulse_cnt + 1'b1;
      scl_drive_low_o <= (state_nxt == ST_PULSE_LO) || (state_nxt == ST_STOP_LO) ||
                         (state_nxt == ST_STOP_SDA);
      sda_drive_low_o <= (state_nxt == ST_STOP_SDA) || (state_nxt == ST_STOP_RISE);
      busy_o          <= (state_nxt != ST_IDLE);
      done_o          <= fin;
      if (accept) begin
        ok_o      <= 1'b0;
        scl_err_o <= 1'b0;
        sda_err_o <= 1'b0;
      end else if (fin) begin
        ok_o      <= (fin_res == RES_OK);
        scl_err_o <= (fin_res == RES_SCL);
        sda_err_o <= (fin_res == RES_SDA);
      end
    end
  end

  // ---------------- assertions ----------------
  logic [PC_W+1:0] chk_pulls;
  logic            chk_scl_prev;

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      chk_pulls    <= '0;
      chk_scl_prev <= 1'b0;
    end else begin
      chk_scl_prev <= scl_drive_low_o;
      if (scl_drive_low_o && !chk_scl_prev) chk_pulls <= chk_pulls + 1'b1;
    end
  end

  assert_pull_limit_R5: assert property (@(posedge clk) disable iff (rst)
    int'(chk_pulls) <= MAX_PULSES + 1);

  assert_no_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low_o) |-> scl_drive_low_o);

  assert_sda_free_high_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_drive_low_o) |-> !scl_drive_low_o);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_one_result_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $countones({ok_o, scl_err_o, sda_err_o}) == 1);

  assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!scl_drive_low_o && !sda_drive_low_o));

endmodule

// File: tb/test_i2c_bus_recover.sv
module test_i2c_bus_recover;

  localparam int CNT_W = 20;
  localparam int HALF  = 8;
  localparam int TMO   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] timeout_i = CNT_W'(TMO);
  logic scl_drv, sda_drv, busy_o, done_o, ok_o, scl_err_o, sda_err_o;
  logic tb_scl_hold = 1'b0;
  logic dev_sda_low = 1'b0;
  logic scl_line, sda_line;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int dev_left = 0;
  int falls, lows_half, lows_double, stops, starts, done_cnt, scl_drv_seen;
  int low_begin;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_sda_drv = 1'b0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign scl_line = !(scl_drv || tb_scl_hold);
  assign sda_line = !(sda_drv || dev_sda_low);

  i2c_bus_recover #(.CNT_W(CNT_W), .HALF_CYCLES(HALF), .MAX_PULSES(9), .SYNC_STAGES(2))
  i_i2c_bus_recover (
    .clk(clk), .rst(rst), .start_i(start_i), .timeout_i(timeout_i),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low_o(scl_drv), .sda_drive_low_o(sda_drv),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
    .scl_err_o(scl_err_o), .sda_err_o(sda_err_o)
  );

  // bus monitor and device model, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (scl_drv) scl_drv_seen++;
    if (done_o) done_cnt++;
    if (prev_scl && !scl_line) begin
      falls++;
      low_begin = cyc;
      if (dev_left > 0) begin
        dev_left--;
        if (dev_left == 0) dev_sda_low = 1'b0;
      end
    end
    if (!prev_scl && scl_line) begin
      if (cyc - low_begin == HALF) lows_half++;
      else if (cyc - low_begin == 2*HALF) lows_double++;
    end
    if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
    if (scl_line && sda_drv && !prev_sda_drv) starts++;
    prev_scl = scl_line;
    prev_sda = sda_line;
    prev_sda_drv = sda_drv;
  end

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    falls = 0; lows_half = 0; lows_double = 0; stops = 0;
    starts = 0; done_cnt = 0; scl_drv_seen = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 1;
    while (!done_o && cycles < 3000) begin
      @(negedge clk); cycles++;
    end
    check(done_o, "R9", "done reached", int'(done_o), 1);
  endtask

  task automatic idle_settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!scl_drv && !sda_drv, "R1", "drives after reset", int'({scl_drv, sda_drv}), 0);
    check({busy_o, done_o, ok_o, scl_err_o, sda_err_o} == 5'b0, "R1", "status after reset",
          int'({busy_o, done_o, ok_o, scl_err_o, sda_err_o}), 0);
  endtask

  task automatic t_idle_bus();
    int c;
    clear_mon();
    pulse_start();
    wait_done(c);
    check(ok_o && !scl_err_o && !sda_err_o, "R2", "idle bus ok", int'(ok_o), 1);
    check(falls == 0, "R2", "no pulse on idle bus", falls, 0);
    check(scl_drv_seen == 0 && stops == 0, "R2", "no drive on idle bus", scl_drv_seen, 0);
  endtask

  task automatic t_scl_stuck();
    int c;
    clear_mon();
    tb_scl_hold = 1'b1;
    idle_settle();
    pulse_start();
    wait_done(c);
    check(scl_err_o && !ok_o && !sda_err_o, "R3", "scl stuck flag", int'(scl_err_o), 1);
    check(scl_drv_seen == 0, "R3", "no clocking while stuck", scl_drv_seen, 0);
    check(c >= TMO && c <= TMO + 8, "R3", "stuck detect time", c, TMO);
    @(negedge clk);
    check(!busy_o, "R11", "busy low after scl stuck", int'(busy_o), 0);
    tb_scl_hold = 1'b0;
    idle_settle();
  endtask

  task automatic t_sda_hold(input int k);
    int c;
    clear_mon();
    dev_left = k;
    dev_sda_low = 1'b1;
    idle_settle();
    pulse_start();
    wait_done(c);
    check(!busy_o, "R11", "busy low with done", int'(busy_o), 0);
    if (k <= 9) begin
      check(ok_o && !sda_err_o && !scl_err_o, "R4", "recovered", int'(ok_o), 1);
      check(falls == k + 1, "R4", "pulses plus stop fall", falls, k + 1);
      check(lows_half == k, "R8", "pulse low width", lows_half, k);
      check(stops == 1, "R6", "stop seen", stops, 1);
      check(lows_double == 1, "R6", "stop low period", lows_double, 1);
      check(scl_line && sda_line, "R6", "bus released", int'({scl_line, sda_line}), 3);
    end else begin
      check(sda_err_o && !ok_o && !scl_err_o, "R5", "sda stuck flag", int'(sda_err_o), 1);
      check(falls == 9, "R5", "nine pulses max", falls, 9);
      check(stops == 0, "R5", "no stop after failure", stops, 0);
    end
    check(starts == 0, "R7", "no start created", starts, 0);
    repeat (20) @(negedge clk);
    check(done_cnt == 1, "R9", "single done", done_cnt, 1);
    check(k > 9 ? sda_err_o : ok_o, "R9", "result held", 0, 1);
    if (k > 9) check(falls == 9, "R5", "no clocking after failure", falls, 9);
    dev_left = 0;
    dev_sda_low = 1'b0;
    idle_settle();
  endtask

  task automatic t_kick_while_busy();
    int c;
    clear_mon();
    dev_left = 4;
    dev_sda_low = 1'b1;
    idle_settle();
    pulse_start();
    repeat (30) @(negedge clk);
    check(busy_o, "R11", "busy mid run", int'(busy_o), 1);
    pulse_start();
    wait_done(c);
    repeat (20) @(negedge clk);
    check(ok_o, "R10", "run completes", int'(ok_o), 1);
    check(falls == 5, "R10", "pulse count unchanged", falls, 5);
    check(done_cnt == 1, "R10", "one done", done_cnt, 1);
    dev_left = 0;
    dev_sda_low = 1'b0;
    idle_settle();
  endtask

  initial begin
    while (cyc < 150000 && !finished) @(negedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_bus();
    t_scl_stuck();
    t_sda_hold(1);
    t_sda_hold(3);
    t_sda_hold(9);
    t_sda_hold(12);
    t_kick_while_busy();
    t_idle_bus();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule